// File: doc/BRIEF.md
# Banked Register File with Three-Way Operand Addressing

This block holds the data registers of a small 8-bit processor core. There are sixteen banks of sixteen byte-wide cells and a window of sixteen global slots. Instructions name a register with a 5-bit operand. The block turns that operand, together with an 8-bit pointer register, into one physical location.

Three resolution modes exist:

- **Direct.** Operands 0x01 to 0x0F go straight to the global slot with the same number.
- **Semi-direct.** Operands 0x10 to 0x1F use the pointer's upper nibble as a bank number and the operand's lower nibble as the cell inside that bank.
- **Indirect.** Operand 0x00 is a pseudo-register. It makes the whole 8-bit pointer the address.

The pointer itself lives in global slot 0x04 and is visible on a port. Its bank nibble can also be loaded by a separate bank-select strobe. Writes are synchronous. Reads are combinational from the resolved location.

The global slots have dedicated meanings elsewhere in the core (timer, program counter low byte, status, I/O ports). Here every slot except the pseudo-register and the pointer is plain storage.

Top module: `regfile_banked`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the pointer and global slots 0x01 to 0x0F to zero.
- R2: Operands 0x01 to 0x0F read and write the global slot numbered by operand bits 3:0, whatever value the pointer holds.
- R3: Operands 0x10 to 0x1F access bank `selPtr[7:4]`, cell `opnd[3:0]`. The pointer's bits 3:0 have no effect, and all sixteen banks, bank 0 included, are reachable this way.
- R4: Operand 0x00 uses `selPtr` as the address. Values 0x01 to 0x0F hit the matching global slot, and values 0x10 to 0xFF hit bank `selPtr[7:4]`, cell `selPtr[3:0]`.
- R5: Indirect pointer values 0x00 to 0x0F never touch bank 0. A write through such a pointer lands in a global slot and leaves bank 0 unchanged.
- R6: When the operand is 0x00 and the pointer is 0x00, the read value is 0x00 and a write changes no register.
- R7: The pointer occupies global slot 0x04. It is written and read there like any other slot, and its current value is always driven on `selPtr`.
- R8: With `bankLd` high at a clock edge, `selPtr[7:4]` takes `bankVal` and `selPtr[3:0]` is kept. If a write to slot 0x04 happens in the same cycle, `bankVal` supplies bits 7:4 and `wrData` supplies bits 3:0.
- R9: Storage changes only at a rising edge with `wrEn` high. `rdData` follows `opnd` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opnd | input | 5 | Register operand from the instruction |
| wrEn | input | 1 | Write strobe for the resolved location |
| wrData | input | 8 | Data to write |
| bankLd | input | 1 | Bank-select strobe, loads pointer bits 7:4 |
| bankVal | input | 4 | Bank number for the bank-select strobe |
| rdData | output | 8 | Combinational read of the resolved location |
| selPtr | output | 8 | Current value of the pointer register |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 4-bit bank field and a 4-bit cell field. With these values the pointer is exactly one byte wide and the bank array holds 256 cells. That makes it practical to fill and read back every banked cell and every global slot. It also brings both ends of the indirect range (0x10 and 0xFF) and the overlap between the pointer's low range and bank 0 within reach of direct checks.

// File: rtl/rfb_pkg.sv
`timescale 1ns/1ps
package rfb_pkg;
  localparam int RF_DATA_W   = 8;
  localparam int RF_IDX_W    = 4;
  localparam int RF_BANK_W   = 4;
  localparam int RF_PTR_W    = RF_BANK_W + RF_IDX_W;
  localparam int RF_OPND_W   = RF_IDX_W + 1;
  localparam int RF_SEL_SLOT = 4;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_SEMI     = 2'd1,
    MODE_INDIRECT = 2'd2,
    MODE_NULL     = 2'd3
  } rfMode_e;

  // strobes from address control to the storage datapath
  typedef struct packed {
    logic                 globWe;
    logic                 bankWe;
    logic                 rdBank;
    logic                 rdNull;
    logic                 bankLd;
    logic [RF_IDX_W-1:0]  globIdx;
    logic [RF_PTR_W-1:0]  bankAddr;
  } rfStrobe_t;
endpackage

// File: rtl/rfb_ctrl.sv
`timescale 1ns/1ps
module rfb_ctrl
  import rfb_pkg::*;
#(
  parameter int IDX_W  = RF_IDX_W,
  parameter int BANK_W = RF_BANK_W
) (
  input  logic [IDX_W:0]            opnd,
  input  logic                      wrEn,
  input  logic                      bankLd,
  input  logic [BANK_W+IDX_W-1:0]   selPtr,
  output rfStrobe_t                 st
);
  localparam int PTR_W  = BANK_W + IDX_W;
  localparam int OPND_W = IDX_W + 1;

  rfMode_e            mode;
  logic [PTR_W-1:0]   effAddr;
  logic               inBank;
  logic [IDX_W-1:0]   opIdx;

  assign opIdx = opnd[IDX_W-1:0];

  // mode decode: the top operand bit selects the banked path,
  // an all-zero operand selects the pointer path
  always_comb begin
    if (opnd[OPND_W-1])
      mode = MODE_SEMI;
    else if (opIdx == '0)
      mode = (selPtr == '0) ? MODE_NULL : MODE_INDIRECT;
    else
      mode = MODE_DIRECT;
  end

  always_comb begin
    unique case (mode)
      MODE_DIRECT:   effAddr = {{BANK_W{1'b0}}, opIdx};
      MODE_SEMI:     effAddr = {selPtr[PTR_W-1:IDX_W], opIdx};
      MODE_INDIRECT: effAddr = selPtr;
      default:       effAddr = '0;
    endcase
  end

  // pointer values whose bank field is zero fall into the global window
  assign inBank = (mode == MODE_SEMI) ||
                  ((mode == MODE_INDIRECT) && (effAddr[PTR_W-1:IDX_W] != '0));

  always_comb begin
    st          = '0;
    st.rdNull   = (mode == MODE_NULL);
    st.rdBank   = inBank;
    st.globWe   = wrEn && !inBank && (mode != MODE_NULL);
    st.bankWe   = wrEn && inBank;
    st.bankLd   = bankLd;
    st.globIdx  = effAddr[IDX_W-1:0];
    st.bankAddr = effAddr;
  end
endmodule

// File: rtl/rfb_data.sv
`timescale 1ns/1ps
module rfb_data
  import rfb_pkg::*;
#(
  parameter int DATA_W   = RF_DATA_W,
  parameter int IDX_W    = RF_IDX_W,
  parameter int BANK_W   = RF_BANK_W,
  parameter int SEL_SLOT = RF_SEL_SLOT
) (
  input  logic               clk,
  input  logic               rst,
  input  rfStrobe_t          st,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [BANK_W-1:0]  bankVal,
  output logic [DATA_W-1:0]  rdData,
  output logic [DATA_W-1:0]  selPtr
);
  localparam int ENTRIES  = 1 << IDX_W;
  localparam int BANK_CNT = 1 << BANK_W;
  localparam int CELLS    = BANK_CNT * ENTRIES;
  localparam int PTR_W    = BANK_W + IDX_W;

  logic [DATA_W-1:0] globVal [ENTRIES];
  logic [DATA_W-1:0] bankMem [CELLS];

  for (genvar g = 0; g < ENTRIES; g++) begin : gGlob
    if (g == 0) begin : gPseudo
      assign globVal[g] = '0;
    end else if (g == SEL_SLOT) begin : gSel
      logic [DATA_W-1:0] selQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          selQ <= '0;
        end else begin
          if (st.globWe && st.globIdx == IDX_W'(g))
            selQ <= wrData;
          if (st.bankLd)
            selQ[PTR_W-1:IDX_W] <= bankVal;
        end
      end
      assign globVal[g] = selQ;
    end else begin : gPlain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (st.globWe && st.globIdx == IDX_W'(g))
          q <= wrData;
      end
      assign globVal[g] = q;
    end
  end

  always_ff @(posedge clk) begin
    if (st.bankWe)
      bankMem[st.bankAddr] <= wrData;
  end

  always_comb begin
    if (st.rdNull)
      rdData = '0;
    else if (st.rdBank)
      rdData = bankMem[st.bankAddr];
    else
      rdData = globVal[st.globIdx];
  end

  assign selPtr = globVal[SEL_SLOT];
endmodule

// File: rtl/regfile_banked.sv
`timescale 1ns/1ps
module regfile_banked
  import rfb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [RF_OPND_W-1:0]  opnd,
  input  logic                  wrEn,
  input  logic [RF_DATA_W-1:0]  wrData,
  input  logic                  bankLd,
  input  logic [RF_BANK_W-1:0]  bankVal,
  output logic [RF_DATA_W-1:0]  rdData,
  output logic [RF_DATA_W-1:0]  selPtr
);
  rfStrobe_t strobes;

  rfb_ctrl #(.IDX_W(RF_IDX_W), .BANK_W(RF_BANK_W)) u_ctrl (
    .opnd   (opnd),
    .wrEn   (wrEn),
    .bankLd (bankLd),
    .selPtr (selPtr),
    .st     (strobes)
  );

  rfb_data #(
    .DATA_W(RF_DATA_W), .IDX_W(RF_IDX_W),
    .BANK_W(RF_BANK_W), .SEL_SLOT(RF_SEL_SLOT)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .st      (strobes),
    .wrData  (wrData),
    .bankVal (bankVal),
    .rdData  (rdData),
    .selPtr  (selPtr)
  );
endmodule

// File: rtl/rfb_chk.sv
`timescale 1ns/1ps
module rfb_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] opnd,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       bankLd,
  input logic [3:0] bankVal,
  input logic [7:0] rdData,
  input logic [7:0] selPtr
);
  // R1
  ptr_reset_chk: assert property (@(posedge clk) rst |=> selPtr == 8'h00);

  // R8
  bank_load_chk: assert property (@(posedge clk) disable iff (rst)
    bankLd |=> selPtr[7:4] == $past(bankVal));

  // R7
  ptr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && opnd == 5'h04 && !bankLd) |=> selPtr == $past(wrData));

  // R6
  null_read_chk: assert property (@(posedge clk) disable iff (rst)
    (opnd == 5'h00 && selPtr == 8'h00) |-> rdData == 8'h00);

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !bankLd) |=> $stable(selPtr));

  // R2
  direct_rdback_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !bankLd && $past(wrEn) && !$past(rst) && !$past(bankLd) &&
     opnd == $past(opnd) && opnd >= 5'h05 && opnd <= 5'h0F)
    |-> rdData == $past(wrData));
endmodule

bind regfile_banked rfb_chk u_chk (.*);

// File: tb/sim_regfile_banked.sv
`timescale 1ns/1ps
module sim_regfile_banked;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] opnd = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       bankLd = 1'b0;
  logic [3:0] bankVal = '0;
  logic [7:0] rdData;
  logic [7:0] selPtr;

  regfile_banked u0 (.*);

  always #2 clk = ~clk;

  typedef struct {
    bit         isPtr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];
  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  logic [7:0] gm [16];
  logic [7:0] bm [256];

  task automatic idle();
    @(negedge clk);
    wrEn = 0; bankLd = 0;
  endtask

  task automatic wr(input logic [4:0] o, input logic [7:0] d);
    @(negedge clk);
    opnd = o; wrEn = 1; wrData = d; bankLd = 0;
  endtask

  task automatic bsel(input logic [3:0] b);
    @(negedge clk);
    wrEn = 0; bankLd = 1; bankVal = b;
  endtask

  task automatic chkRd(input string tag, input logic [4:0] o, input logic [7:0] e);
    @(negedge clk);
    opnd = o; wrEn = 0; bankLd = 0;
    sb.push_back('{1'b0, e, tag});
  endtask

  task automatic chkPtr(input string tag, input logic [7:0] e);
    @(negedge clk);
    wrEn = 0; bankLd = 0;
    sb.push_back('{1'b1, e, tag});
  endtask

  // monitor: compares one expected item per cycle before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (sb.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb.pop_front();
        got = it.isPtr ? selPtr : rdData;
        nRun++;
        if (got !== it.exp) begin
          nFail++;
          $display("FAIL %s: got %02h expected %02h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chkPtr("R1 pointer after reset", 8'h00);
    for (int g = 1; g < 16; g++) chkRd("R1 global after reset", 5'(g), 8'h00);
    for (int g = 0; g < 16; g++) gm[g] = 8'h00;

    // R2: direct writes and readback
    for (int g = 1; g < 16; g++) begin
      if (g != 4) begin
        wr(5'(g), 8'(g * 17) ^ 8'hA5);
        gm[g] = 8'(g * 17) ^ 8'hA5;
      end
    end
    for (int g = 1; g < 16; g++) chkRd("R2 direct readback", 5'(g), gm[g]);

    // R3: fill every bank through semi-direct access, bank 0 included
    for (int b = 0; b < 16; b++) begin
      bsel(4'(b));
      for (int i = 0; i < 16; i++) begin
        wr(5'h10 | 5'(i), 8'(b * 16 + i) ^ 8'h5A);
        bm[b * 16 + i] = 8'(b * 16 + i) ^ 8'h5A;
      end
    end
    for (int b = 0; b < 16; b++) begin
      bsel(4'(b));
      for (int i = 0; i < 16; i++)
        chkRd("R3 semi-direct readback", 5'h10 | 5'(i), bm[b * 16 + i]);
    end

    // R7 / R3: pointer written as slot 4; its low nibble ignored by semi mode
    wr(5'h04, 8'h3F); gm[4] = 8'h3F;
    chkPtr("R7 pointer via slot 4", 8'h3F);
    chkRd("R7 slot 4 readback", 5'h04, 8'h3F);
    chkRd("R3 low nibble ignored", 5'h12, bm[8'h32]);
    // R2: direct path independent of pointer
    chkRd("R2 direct with ptr 3F", 5'h0B, gm[11]);
    wr(5'h04, 8'hC7); gm[4] = 8'hC7;
    chkRd("R2 direct with ptr C7", 5'h0B, gm[11]);

    // R4: indirect at both ends of the banked range
    wr(5'h04, 8'h10);
    chkRd("R4 indirect 10", 5'h00, bm[8'h10]);
    wr(5'h04, 8'hFF);
    chkRd("R4 indirect FF", 5'h00, bm[8'hFF]);
    wr(5'h00, 8'h3C); bm[8'hFF] = 8'h3C;
    bsel(4'hF);
    chkRd("R4 indirect write FF seen semi", 5'h1F, 8'h3C);
    wr(5'h04, 8'h0A);
    chkRd("R4 indirect to global 0A", 5'h00, gm[10]);
    wr(5'h04, 8'h0C);
    wr(5'h00, 8'hE1); gm[12] = 8'hE1;
    chkRd("R4 indirect write global 0C", 5'h0C, 8'hE1);

    // R5: low pointer values go to globals, not bank 0
    wr(5'h04, 8'h03);
    wr(5'h00, 8'h77); gm[3] = 8'h77;
    bsel(4'h0);
    chkRd("R5 bank0 cell 3 untouched", 5'h13, bm[8'h03]);
    chkRd("R5 global 3 written", 5'h03, 8'h77);

    // R6: pointer 0 through pseudo-register
    wr(5'h04, 8'h00); gm[4] = 8'h00;
    chkRd("R6 null read", 5'h00, 8'h00);
    wr(5'h00, 8'h99);
    chkPtr("R6 pointer unchanged", 8'h00);
    chkRd("R6 bank0 cell 0 unchanged", 5'h10, bm[8'h00]);
    for (int g = 1; g < 16; g++) chkRd("R6 globals unchanged", 5'(g), gm[g]);

    // R8: bank select alone and together with a pointer write
    wr(5'h04, 8'h21);
    bsel(4'h9);
    chkPtr("R8 bank select keeps low nibble", 8'h91);
    @(negedge clk);
    opnd = 5'h04; wrEn = 1; wrData = 8'hAB; bankLd = 1; bankVal = 4'h6;
    chkPtr("R8 simultaneous load", 8'h6B);
    chkRd("R8 slot 4 after simultaneous", 5'h04, 8'h6B);
    gm[4] = 8'h6B;

    // R9: no write without wrEn
    @(negedge clk);
    opnd = 5'h0E; wrEn = 0; wrData = 8'h55; bankLd = 0;
    chkRd("R9 no write without strobe", 5'h0E, gm[14]);
    chkRd("R9 banked no write", 5'h15, bm[8'h65]);

    // R1: reset again clears globals and pointer
    @(negedge clk);
    rst = 1; wrEn = 0; bankLd = 0;
    @(negedge clk);
    rst = 0;
    chkPtr("R1 pointer after second reset", 8'h00);
    for (int g = 1; g < 16; g++) chkRd("R1 global after second reset", 5'(g), 8'h00);

    repeat (3) idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule